// File: doc/BRIEF.md
# Ethernet Receive Frame Length Validator

This block sits behind the receive decoder of an Ethernet MAC and judges every incoming frame on its size. It sees the frame one byte per valid beat, marked with start and end flags, together with the verdict of an external CRC checker on the end beat. It counts the bytes and picks up the 802.3 type/length field. One cycle after the final byte it issues a single result: accept or reject, a reason code, the length to report and the echoed CRC status.

Five configuration inputs adjust the verdict. They widen the size limit in two steps, enable the length-field consistency check, strip the trailing frame check sequence from the reported length and the forwarded stream, and make CRC errors non-fatal. The bytes themselves are forwarded through a four-byte holding line. This lets the trailing frame check sequence be tagged, or withheld, without lookahead. The line empties during the first four idle cycles after a frame. The receive path must therefore leave at least four idle cycles between frames, and normal inter-frame gaps already do.

Top module: `eth_rx_len_check`

## Requirements
- R1: A frame whose total byte count, including the four check bytes, is below 64 is rejected with reason code 2 (runt).
- R2: The size limit is 1518 bytes when both size options are off, 1536 bytes when only `cfg_long_en` is set, and JUMBO_MAX (default 10240) whenever `cfg_jumbo_en` is set. A frame longer than the active limit is rejected with reason code 1.
- R3: The byte count saturates at JUMBO_MAX+1. With stripping off, the reported length of any frame never exceeds JUMBO_MAX+1.
- R4: The length field is the byte at zero-based offset 12 (high) followed by offset 13 (low). With `cfg_lf_check` set and the field below 0x0600, a frame whose total count is less than field+18 is rejected with reason code 3. With the option off, or with the field at 0x0600 or above, the field has no effect.
- R5: With `in_fcs_err` high on the end beat, the frame is rejected with reason code 4 unless `cfg_ignore_fcs` is set. `res_fcs_err` always repeats that input.
- R6: When several reasons hold, the lowest non-zero code is reported. `res_accept` is high exactly when the code is 0.
- R7: `res_len` equals the byte count, less 4 when `cfg_strip_fcs` is set (never below 0).
- R8: `res_valid` is a one-cycle pulse in the cycle after the end beat.
- R9: With stripping off, every input byte appears on `fwd_data` in order with `fwd_valid`. The final four carry `fwd_fcs`, and `fwd_last` marks the final byte.
- R10: With stripping on, the final four bytes never appear with `fwd_valid`. `fwd_last` marks the byte just before them.
- R11: After reset, `res_valid` and `fwd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte present this cycle |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Received byte |
| in_fcs_err | input | 1 | CRC verdict, valid on the end beat |
| cfg_long_en | input | 1 | Raise limit to 1536 bytes |
| cfg_jumbo_en | input | 1 | Raise limit to JUMBO_MAX |
| cfg_lf_check | input | 1 | Enable length-field consistency check |
| cfg_strip_fcs | input | 1 | Remove check bytes from length and stream |
| cfg_ignore_fcs | input | 1 | Do not reject on CRC error |
| res_valid | output | 1 | Result pulse |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 3 | 0 ok, 1 too long, 2 runt, 3 length field, 4 CRC |
| res_len | output | clog2(JUMBO_MAX+2) | Reported length |
| res_fcs_err | output | 1 | Echo of CRC verdict |
| fwd_valid | output | 1 | Forwarded byte present |
| fwd_data | output | 8 | Forwarded byte |
| fwd_last | output | 1 | Last forwarded byte of frame |
| fwd_fcs | output | 1 | Byte is one of the trailing four |

## Verification
Frames are placed one byte either side of each size limit, 63/64, 1518/1519, 1536/1537 and 10240/10241, under each size option. This separates an off-by-one from a wrong tier choice. A 10300-byte frame shows that the count holds at its ceiling rather than wrapping. Length-field frames sit one byte below and at field+18, and fields of 0x05FF and 0x0600 cover the type/length boundary. Combined faults (runt with CRC error, runt with length-field error, overlong with CRC error) pin down the priority. Two 70-byte frames with stripping off and on check the forwarded byte order, the tail tagging and the end marker.

// File: rtl/rxlen_pkg.sv
package rxlen_pkg;

    typedef enum logic [2:0] {
        RSN_OK        = 3'd0,
        RSN_TOO_LONG  = 3'd1,
        RSN_RUNT      = 3'd2,
        RSN_LEN_FIELD = 3'd3,
        RSN_FCS       = 3'd4
    } rsn_e;

    localparam int STD_MAX     = 1518;
    localparam int MID_MAX     = 1536;
    localparam int MIN_LEN     = 64;
    localparam int TYPE_FLOOR  = 16'h0600;
    localparam int LF_OVERHEAD = 18;
    localparam int FCS_BYTES   = 4;
    localparam int LF_HI_IDX   = 12;
    localparam int LF_LO_IDX   = 13;

    typedef struct packed {
        logic long_en;
        logic jumbo_en;
        logic lf_check;
        logic strip_fcs;
        logic ignore_fcs;
    } cfg_t;

    typedef struct packed {
        logic too_long;
        logic runt;
        logic lf_err;
        logic fcs_bad;
    } flags_t;

    function automatic rsn_e pick_reason(flags_t f);
        if (f.too_long)     return RSN_TOO_LONG;
        else if (f.runt)    return RSN_RUNT;
        else if (f.lf_err)  return RSN_LEN_FIELD;
        else if (f.fcs_bad) return RSN_FCS;
        else                return RSN_OK;
    endfunction

endpackage

// File: rtl/rxlen_count.sv
module rxlen_count
    import rxlen_pkg::*;
#(
    parameter int JUMBO_MAX = 10240,
    parameter int CNT_W     = $clog2(JUMBO_MAX + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [7:0]       in_data,
    output logic [CNT_W-1:0] len_now,
    output logic [15:0]      lf_now
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(JUMBO_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [15:0]      lf_q;

    always_comb begin
        if (in_sof)          len_now = CNT_W'(1);
        else if (cnt_q >= SAT) len_now = SAT;
        else                 len_now = cnt_q + CNT_W'(1);

        if (!in_sof && cnt_q == CNT_W'(LF_LO_IDX)) lf_now = {lf_q[15:8], in_data};
        else                                       lf_now = lf_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lf_q  <= 16'hFFFF;
        end else if (in_valid) begin
            cnt_q <= len_now;
            if (in_sof)                                lf_q <= 16'hFFFF;
            else if (cnt_q == CNT_W'(LF_HI_IDX))       lf_q[15:8] <= in_data;
            else if (cnt_q == CNT_W'(LF_LO_IDX))       lf_q[7:0]  <= in_data;
        end
    end

    assert_cnt_cap_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= SAT);

endmodule

// File: rtl/rxlen_judge.sv
module rxlen_judge
    import rxlen_pkg::*;
#(
    parameter int JUMBO_MAX = 10240,
    parameter int CNT_W     = $clog2(JUMBO_MAX + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [CNT_W-1:0] len_now,
    input  logic [15:0]      lf_now,
    input  cfg_t             cfg,
    input  logic             fcs_err,
    output logic             res_valid,
    output logic             res_accept,
    output logic [2:0]       res_reason,
    output logic [CNT_W-1:0] res_len,
    output logic             res_fcs_err
);
    localparam logic [31:0] SAT = 32'(JUMBO_MAX + 1);

    logic [31:0]      len32;
    logic [31:0]      limit;
    flags_t           flags;
    logic [CNT_W-1:0] rep_len;
    logic             strip_q;

    always_comb begin
        len32 = 32'(len_now);
        if (cfg.jumbo_en)     limit = 32'(JUMBO_MAX);
        else if (cfg.long_en) limit = 32'(MID_MAX);
        else                  limit = 32'(STD_MAX);

        flags.too_long = len32 > limit;
        flags.runt     = len32 < 32'(MIN_LEN);
        flags.lf_err   = cfg.lf_check && (32'(lf_now) < 32'(TYPE_FLOOR))
                         && (len32 < 32'(lf_now) + 32'(LF_OVERHEAD));
        flags.fcs_bad  = fcs_err && !cfg.ignore_fcs;

        if (!cfg.strip_fcs)                       rep_len = len_now;
        else if (len32 < 32'(FCS_BYTES))          rep_len = '0;
        else                                      rep_len = len_now - CNT_W'(FCS_BYTES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_accept  <= 1'b0;
            res_reason  <= RSN_OK;
            res_len     <= '0;
            res_fcs_err <= 1'b0;
            strip_q     <= 1'b0;
        end else begin
            res_valid <= fire;
            if (fire) begin
                res_accept  <= ~|flags;
                res_reason  <= pick_reason(flags);
                res_len     <= rep_len;
                res_fcs_err <= fcs_err;
                strip_q     <= cfg.strip_fcs;
            end
        end
    end

    assert_len_cap_R3: assert property (@(posedge clk) disable iff (rst)
        res_valid && !strip_q |-> 32'(res_len) <= SAT);

    assert_accept_code_R6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_accept == (res_reason == RSN_OK)));

    assert_runt_R1: assert property (@(posedge clk) disable iff (rst)
        res_valid && !strip_q && 32'(res_len) < 32'(MIN_LEN) |-> !res_accept);

endmodule

// File: rtl/rxlen_tail.sv
module rxlen_tail
    import rxlen_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = FCS_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic [DW-1:0] in_data,
    input  logic          strip,
    output logic          fwd_valid,
    output logic [DW-1:0] fwd_data,
    output logic          fwd_last,
    output logic          fwd_fcs
);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

    logic [DW-1:0]     hold [DEPTH];
    logic [FILL_W-1:0] fill_q, drain_q, fill_inc;
    logic              dstrip_q;
    logic [IDX_W-1:0]  pick;

    assign fill_inc = (fill_q == FULL) ? FULL : fill_q + FILL_W'(1);
    assign pick     = IDX_W'(drain_q - FILL_W'(1));

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) if (in_valid) hold[g] <= in_data;
        end else begin : g_body
            always_ff @(posedge clk) if (in_valid) hold[g] <= hold[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q    <= '0;
            drain_q   <= '0;
            dstrip_q  <= 1'b0;
            fwd_valid <= 1'b0;
            fwd_data  <= '0;
            fwd_last  <= 1'b0;
            fwd_fcs   <= 1'b0;
        end else begin
            fwd_valid <= 1'b0;
            fwd_last  <= 1'b0;
            fwd_fcs   <= 1'b0;
            if (in_valid) begin
                fill_q <= in_sof ? FILL_W'(1) : fill_inc;
                if (!in_sof && fill_q == FULL) begin
                    fwd_valid <= 1'b1;
                    fwd_data  <= hold[DEPTH-1];
                    fwd_last  <= in_eof && strip;
                end
                if (in_eof) begin
                    drain_q  <= in_sof ? FILL_W'(1) : fill_inc;
                    dstrip_q <= strip;
                end
            end else if (drain_q != '0) begin
                fwd_valid <= !dstrip_q;
                fwd_data  <= hold[pick];
                fwd_fcs   <= 1'b1;
                fwd_last  <= (drain_q == FILL_W'(1)) && !dstrip_q;
                drain_q   <= drain_q - FILL_W'(1);
                fill_q    <= '0;
            end
        end
    end

    assert_strip_hidden_R10: assert property (@(posedge clk) disable iff (rst)
        fwd_fcs && $past(drain_q == FILL_W'(1)) && dstrip_q |-> !fwd_valid);

    assert_no_overfill_R9: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FULL && drain_q <= FULL);

endmodule

// File: rtl/eth_rx_len_check.sv
module eth_rx_len_check
    import rxlen_pkg::*;
#(
    parameter int JUMBO_MAX = 10240
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic                             in_sof,
    input  logic                             in_eof,
    input  logic [7:0]                       in_data,
    input  logic                             in_fcs_err,
    input  logic                             cfg_long_en,
    input  logic                             cfg_jumbo_en,
    input  logic                             cfg_lf_check,
    input  logic                             cfg_strip_fcs,
    input  logic                             cfg_ignore_fcs,
    output logic                             res_valid,
    output logic                             res_accept,
    output logic [2:0]                       res_reason,
    output logic [$clog2(JUMBO_MAX+2)-1:0]   res_len,
    output logic                             res_fcs_err,
    output logic                             fwd_valid,
    output logic [7:0]                       fwd_data,
    output logic                             fwd_last,
    output logic                             fwd_fcs
);
    localparam int CNT_W = $clog2(JUMBO_MAX + 2);

    cfg_t             cfg;
    logic [CNT_W-1:0] len_now;
    logic [15:0]      lf_now;

    assign cfg = '{long_en: cfg_long_en, jumbo_en: cfg_jumbo_en, lf_check: cfg_lf_check,
                   strip_fcs: cfg_strip_fcs, ignore_fcs: cfg_ignore_fcs};

    rxlen_count #(.JUMBO_MAX(JUMBO_MAX), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .len_now(len_now), .lf_now(lf_now)
    );

    rxlen_judge #(.JUMBO_MAX(JUMBO_MAX), .CNT_W(CNT_W)) u_judge (
        .clk(clk), .rst(rst), .fire(in_valid && in_eof), .len_now(len_now),
        .lf_now(lf_now), .cfg(cfg), .fcs_err(in_fcs_err),
        .res_valid(res_valid), .res_accept(res_accept), .res_reason(res_reason),
        .res_len(res_len), .res_fcs_err(res_fcs_err)
    );

    rxlen_tail #(.DW(8), .DEPTH(FCS_BYTES)) u_tail (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .strip(cfg_strip_fcs),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_last(fwd_last), .fwd_fcs(fwd_fcs)
    );

    assert_result_timing_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid && in_eof));

    assert_fcs_echo_R5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_fcs_err == $past(in_fcs_err));

endmodule

// File: tb/eth_rx_len_check_bench.sv
module eth_rx_len_check_bench;
    localparam int JMAX = 10240;
    localparam int LW   = $clog2(JMAX + 2);

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] lf;
        logic [4:0]  cfg;   // {long, jumbo, lf_check, strip, ignore}
        logic        fcs;
        logic [2:0]  rsn;
        logic [15:0] rlen;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{16'd64,    16'h0800, 5'b00000, 1'b0, 3'd0, 16'd64},
        '{16'd63,    16'h0800, 5'b00000, 1'b0, 3'd2, 16'd63},
        '{16'd1518,  16'h0800, 5'b00000, 1'b0, 3'd0, 16'd1518},
        '{16'd1519,  16'h0800, 5'b00000, 1'b0, 3'd1, 16'd1519},
        '{16'd1519,  16'h0800, 5'b10000, 1'b0, 3'd0, 16'd1519},
        '{16'd1536,  16'h0800, 5'b10000, 1'b0, 3'd0, 16'd1536},
        '{16'd1537,  16'h0800, 5'b10000, 1'b0, 3'd1, 16'd1537},
        '{16'd1537,  16'h0800, 5'b01000, 1'b0, 3'd0, 16'd1537},
        '{16'd2000,  16'h0800, 5'b11000, 1'b0, 3'd0, 16'd2000},
        '{16'd117,   16'h0064, 5'b00100, 1'b0, 3'd3, 16'd117},
        '{16'd118,   16'h0064, 5'b00100, 1'b0, 3'd0, 16'd118},
        '{16'd117,   16'h0064, 5'b00000, 1'b0, 3'd0, 16'd117},
        '{16'd100,   16'h05FF, 5'b00100, 1'b0, 3'd3, 16'd100},
        '{16'd100,   16'h0600, 5'b00100, 1'b0, 3'd0, 16'd100},
        '{16'd64,    16'h0800, 5'b00000, 1'b1, 3'd4, 16'd64},
        '{16'd64,    16'h0800, 5'b00001, 1'b1, 3'd0, 16'd64},
        '{16'd64,    16'h0800, 5'b00010, 1'b0, 3'd0, 16'd60},
        '{16'd63,    16'h0800, 5'b00000, 1'b1, 3'd2, 16'd63},
        '{16'd1519,  16'h0800, 5'b00000, 1'b1, 3'd1, 16'd1519},
        '{16'd117,   16'h0064, 5'b00100, 1'b1, 3'd3, 16'd117},
        '{16'd63,    16'h0064, 5'b00100, 1'b0, 3'd2, 16'd63},
        '{16'd10240, 16'h0800, 5'b01000, 1'b0, 3'd0, 16'd10240},
        '{16'd10241, 16'h0800, 5'b01000, 1'b0, 3'd1, 16'd10241},
        '{16'd10300, 16'h0800, 5'b01000, 1'b0, 3'd1, 16'd10241},
        '{16'd10300, 16'h0800, 5'b01010, 1'b0, 3'd1, 16'd10237},
        '{16'd200,   16'h0800, 5'b10010, 1'b0, 3'd0, 16'd196}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 0, in_sof = 0, in_eof = 0, in_fcs_err = 0;
    logic [7:0] in_data = '0;
    logic [4:0] cfg = '0;
    logic res_valid, res_accept, res_fcs_err, fwd_valid, fwd_last, fwd_fcs;
    logic [2:0] res_reason;
    logic [LW-1:0] res_len;
    logic [7:0] fwd_data;

    int n_run = 0, n_fail = 0, cycles = 0;

    always #5 clk = ~clk;

    eth_rx_len_check #(.JUMBO_MAX(JMAX)) u_eth_rx_len_check (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .in_fcs_err(in_fcs_err),
        .cfg_long_en(cfg[4]), .cfg_jumbo_en(cfg[3]), .cfg_lf_check(cfg[2]),
        .cfg_strip_fcs(cfg[1]), .cfg_ignore_fcs(cfg[0]),
        .res_valid(res_valid), .res_accept(res_accept), .res_reason(res_reason),
        .res_len(res_len), .res_fcs_err(res_fcs_err),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_last(fwd_last), .fwd_fcs(fwd_fcs)
    );

    function automatic logic [7:0] pat(int i, logic [15:0] lf);
        if (i == 12) return lf[15:8];
        if (i == 13) return lf[7:0];
        return 8'((i * 7 + 3) & 255);
    endfunction

    // output stream monitor
    logic        mon_clear = 1'b0;
    logic [15:0] mon_lf = '0;
    int mon_n = 0, mon_bad = 0, mon_fcsv = 0, mon_last_idx = -1, mon_last_n = 0;
    always @(negedge clk) begin
        if (mon_clear) begin
            mon_n = 0; mon_bad = 0; mon_fcsv = 0; mon_last_idx = -1; mon_last_n = 0;
        end else if (fwd_valid) begin
            if (fwd_data !== pat(mon_n, mon_lf)) mon_bad++;
            if (fwd_fcs) mon_fcsv++;
            if (fwd_last) begin mon_last_idx = mon_n; mon_last_n++; end
            mon_n++;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            summary();
        end
    end

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(int len, logic [15:0] lf, logic [4:0] c, logic fe);
        @(negedge clk);
        mon_clear = 1'b1; mon_lf = lf;
        @(negedge clk);
        mon_clear = 1'b0;
        cfg = c;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
            in_data = pat(i, lf); in_fcs_err = (i == len - 1) ? fe : 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 0; in_eof = 0; in_fcs_err = 0;
    endtask

    function automatic string rtag(int r);
        case (r)
            1: return "R2";
            2: return "R1";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R11 res_valid after reset", int'(res_valid), 0);
        check("R11 fwd_valid after reset", int'(fwd_valid), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            send(int'(VECS[v].len), VECS[v].lf, VECS[v].cfg, VECS[v].fcs);
            check("R8 res_valid after end beat", int'(res_valid), 1);
            check(rtag(int'(VECS[v].rsn)), int'(res_reason), int'(VECS[v].rsn));
            check("R6 accept", int'(res_accept), int'(VECS[v].rsn == 3'd0));
            check((VECS[v].len > 16'(JMAX + 1)) ? "R3 saturated length" : "R7 length",
                  int'(res_len), int'(VECS[v].rlen));
            check("R5 fcs echo", int'(res_fcs_err), int'(VECS[v].fcs));
            @(negedge clk);
            check("R8 single pulse", int'(res_valid), 0);
            repeat (6) @(negedge clk);
        end

        // R9: stream with tail kept
        send(70, 16'h0800, 5'b00000, 1'b0);
        repeat (7) @(negedge clk);
        check("R9 forwarded count", mon_n, 70);
        check("R9 data order", mon_bad, 0);
        check("R9 tail flagged", mon_fcsv, 4);
        check("R9 last index", mon_last_idx, 69);
        check("R9 one last", mon_last_n, 1);

        // R10: stream with tail stripped
        send(70, 16'h0800, 5'b00010, 1'b0);
        repeat (7) @(negedge clk);
        check("R10 forwarded count", mon_n, 66);
        check("R10 data order", mon_bad, 0);
        check("R10 tail hidden", mon_fcsv, 0);
        check("R10 last index", mon_last_idx, 65);

        summary();
    end
endmodule